// File: doc/BRIEF.md
# Dual-Mode Serial DAC Frame Receiver

This block is the digital front end of an eight-channel DAC. A host sends 16-bit words over three wires: a serial clock, a frame-sync strobe and a data line. The block oversamples all three with a faster system clock and shifts the data in MSB first on each falling serial-clock edge. It decodes a channel address from the top of the word and stores the 12-bit code in that channel's holding register. An active-low load input copies every holding register into its output latch. While load is held low, each channel's output follows its holding register. A serial output repeats the input stream sixteen serial-clock edges later, so several devices can be chained.

A mode input selects one of two framing disciplines. In microcontroller mode the frame-sync must stay low for the whole word, and the word commits when frame-sync rises. If frame-sync rises early, the word is discarded. In DSP mode the frame-sync is only a start pulse, and the word commits on its own after the sixteenth bit. A DSP-mode frame is accepted only when at least one falling serial-clock edge has occurred since the previous frame. A resolution parameter builds reduced-precision variants, which clear the unused low code bits.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset every output latch, `doutOut` and `frameDone` are zero.
- R2: In microcontroller mode (`modeUc`=1), a word is sent with frame-sync low for 16 falling serial-clock edges. The commit follows the rising edge of frame-sync: `frameDone` pulses once, and the holding register of channel `word[14:12]` is loaded with `word[11:0]`, provided `word[15]`=0. There is no commit while frame-sync is still low.
- R3: In microcontroller mode, if frame-sync rises before the 16th falling edge, the frame is discarded: there is no `frameDone` pulse and no register changes.
- R4: In DSP mode (`modeUc`=0), a frame starts on the frame-sync fall and completes on the 16th falling serial-clock edge. It commits and pulses `frameDone` even though frame-sync rose after the first bit.
- R5: In DSP mode, a frame-sync fall is ignored when no falling serial-clock edge has occurred since the previous frame ended or since reset.
- R6: While `loadN` is high the output latches hold their values. While it is low, every latch takes its holding register, so staged writes appear together when `loadN` falls.
- R7: A committed word whose 4-bit field `word[15:12]` is 8 or above writes no holding register, but still pulses `frameDone`.
- R8: On every falling serial-clock edge, frame or not, `doutOut` takes the bit that was sampled 16 falling edges earlier. It reads 0 until 16 edges have occurred since reset.
- R9: With `RES_BITS` below 12, the lowest 12-`RES_BITS` bits of each stored code are forced to zero. For example, 8 bits gives codes of the form 0xFF0 at most.
- R10: In microcontroller mode, an extra falling serial-clock edge after frame-sync rises has no effect, and the next frame is received normally.
- R11: `latchOut` packs channel c into bits [12c+11:12c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, data sampled on its falling edge |
| fsIn | input | 1 | Frame-sync, active low |
| dinIn | input | 1 | Serial data, MSB first |
| modeUc | input | 1 | 1 = microcontroller framing, 0 = DSP framing |
| loadN | input | 1 | Asynchronous active-low latch load |
| doutOut | output | 1 | Serial pass-through delayed by 16 edges |
| frameDone | output | 1 | One-cycle pulse per committed word |
| latchOut | output | CHANNELS*CODE_BITS | Packed output latches |

## Verification
Some behaviours depend on when frame-sync moves relative to the serial clock, so the bench steers each case through tasks that control both lines. Cancellation is driven by raising frame-sync after 1, 8 and 15 bits. Rejection of a DSP frame is driven by starting it directly after a completed frame with no lead edge. The stray edge after a microcontroller commit is a lone serial-clock pulse inserted between two frames. Every falling edge of the whole run also checks the pass-through, so the 16-edge delay is checked across frame boundaries and idle gaps.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_FULL   = 2'd2
  } rxState_e;

  typedef struct packed {
    logic shift;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkRaw,
  input  logic fsRaw,
  input  logic dinRaw,
  input  logic loadNRaw,
  output logic sclkFall,
  output logic fsFall,
  output logic fsRise,
  output logic dinS,
  output logic loadNS
);
  // bit order {loadN, din, fs, sclk}; idle levels chosen so reset makes no edge
  localparam logic [3:0] IDLE_LVL = 4'b1011;

  logic [3:0] stg [STAGES];
  logic [1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_LVL;
      prevQ <= 2'b11;
    end else begin
      stg[0] <= {loadNRaw, dinRaw, fsRaw, sclkRaw};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prevQ <= stg[STAGES-1][1:0];
    end
  end

  assign sclkFall = prevQ[0] & ~stg[STAGES-1][0];
  assign fsFall   = prevQ[1] & ~stg[STAGES-1][1];
  assign fsRise   = ~prevQ[1] & stg[STAGES-1][1];
  assign dinS     = stg[STAGES-1][2];
  assign loadNS   = stg[STAGES-1][3];
endmodule

// File: rtl/dacrx_ctrl.sv
module dacrx_ctrl
  import dacrx_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeUc,
  input  logic      sclkFall,
  input  logic      fsFall,
  input  logic      fsRise,
  output rxStrobe_t strobe,
  output logic      frameDone
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  rxState_e       state;
  logic [CNT_W-1:0] bitCnt;
  logic           armed;
  logic           cancel;

  assign cancel        = (state == ST_ACTIVE) && modeUc && fsRise;
  assign strobe.shift  = (state == ST_ACTIVE) && sclkFall && !cancel;
  assign strobe.commit = (state == ST_FULL) && (!modeUc || fsRise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      armed     <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strobe.commit;
      unique case (state)
        ST_IDLE: begin
          if (fsFall && (modeUc || armed)) begin
            state  <= ST_ACTIVE;
            bitCnt <= '0;
            armed  <= 1'b0;
          end else if (sclkFall) begin
            armed <= 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cancel) begin
            state <= ST_IDLE;
          end else if (strobe.shift) begin
            if (bitCnt == LAST_BIT) state <= ST_FULL;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_FULL: if (strobe.commit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: an early frame-sync rise returns to idle with no commit pulse
  a_r3_cancel_drops: assert property (@(posedge clk) disable iff (!rstN)
    (modeUc && state == ST_ACTIVE && fsRise) |=> (state == ST_IDLE && !frameDone));
  // R4: a full DSP-mode word commits on the next cycle without frame-sync
  a_r4_dsp_self_commit: assert property (@(posedge clk) disable iff (!rstN)
    (!modeUc && state == ST_FULL) |=> frameDone);
  // R2: every commit pulse comes from a full word
  a_r2_done_from_full: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(state) == ST_FULL);
endmodule

// File: rtl/dacrx_datapath.sv
module dacrx_datapath
  import dacrx_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int CODE_BITS = 12,
  parameter int RES_BITS  = 12,
  parameter int WORD_BITS = 16,
  parameter int ADDR_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rxStrobe_t                     strobe,
  input  logic                          sclkFall,
  input  logic                          dinS,
  input  logic                          loadNS,
  output logic                          doutOut,
  output logic [CHANNELS*CODE_BITS-1:0] latchOut
);
  localparam int VEC_W = CHANNELS * CODE_BITS;
  localparam int DROP  = CODE_BITS - RES_BITS;

  logic [WORD_BITS-1:0] shiftQ;
  logic [WORD_BITS-1:0] pipeQ;
  logic [VEC_W-1:0]     holdFlat;
  logic [VEC_W-1:0]     latchFlat;
  logic [ADDR_BITS-1:0] addrField;
  logic [CODE_BITS-1:0] codeKept;

  assign addrField = shiftQ[WORD_BITS-1 -: ADDR_BITS];

  generate
    if (DROP > 0) begin : g_reduced
      assign codeKept = {shiftQ[CODE_BITS-1:DROP], {DROP{1'b0}}};
    end else begin : g_full
      assign codeKept = shiftQ[CODE_BITS-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      pipeQ   <= '0;
      doutOut <= 1'b0;
    end else begin
      if (strobe.shift) shiftQ <= {shiftQ[WORD_BITS-2:0], dinS};
      if (sclkFall) begin
        pipeQ   <= {pipeQ[WORD_BITS-2:0], dinS};
        doutOut <= pipeQ[WORD_BITS-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFlat  <= '0;
      latchFlat <= '0;
    end else begin
      if (strobe.commit) begin
        for (int c = 0; c < CHANNELS; c++) begin
          if (addrField == ADDR_BITS'(c)) holdFlat[c*CODE_BITS +: CODE_BITS] <= codeKept;
        end
      end
      if (!loadNS) latchFlat <= holdFlat;
    end
  end

  assign latchOut = latchFlat;

  // R6: latches frozen while load is released
  a_r6_load_hold: assert property (@(posedge clk) disable iff (!rstN)
    loadNS |=> $stable(latchFlat));
  // R8: pass-through moves only on a serial-clock fall
  a_r8_dout_steps: assert property (@(posedge clk) disable iff (!rstN)
    !sclkFall |=> $stable(doutOut));
  // R7: out-of-range field writes nothing
  a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && int'(addrField) >= CHANNELS) |=> $stable(holdFlat));
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dacrx_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int CODE_BITS   = 12,
  parameter int RES_BITS    = 12,
  parameter int WORD_BITS   = 16,
  parameter int ADDR_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclkIn,
  input  logic                          fsIn,
  input  logic                          dinIn,
  input  logic                          modeUc,
  input  logic                          loadN,
  output logic                          doutOut,
  output logic                          frameDone,
  output logic [CHANNELS*CODE_BITS-1:0] latchOut
);
  logic      sclkFall, fsFall, fsRise, dinS, loadNS;
  rxStrobe_t strobe;

  dacrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkRaw(sclkIn), .fsRaw(fsIn), .dinRaw(dinIn),
    .loadNRaw(loadN), .sclkFall(sclkFall), .fsFall(fsFall), .fsRise(fsRise),
    .dinS(dinS), .loadNS(loadNS)
  );

  dacrx_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeUc(modeUc), .sclkFall(sclkFall),
    .fsFall(fsFall), .fsRise(fsRise), .strobe(strobe), .frameDone(frameDone)
  );

  dacrx_datapath #(
    .CHANNELS(CHANNELS), .CODE_BITS(CODE_BITS), .RES_BITS(RES_BITS),
    .WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sclkFall(sclkFall), .dinS(dinS),
    .loadNS(loadNS), .doutOut(doutOut), .latchOut(latchOut)
  );
endmodule

// File: tb/dac_frame_rx_bench.sv
`timescale 1ns/1ps
module dac_frame_rx_bench;
  localparam int CH = 8;
  localparam int CB = 12;
  localparam int VW = CH * CB;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b1, fs = 1'b1, din = 1'b0, modeUc = 1'b1, loadN = 1'b1;
  logic dout, done, dout2, done2;
  logic [VW-1:0] lat, lat2;

  int checks = 0, errors = 0, doneCnt = 0, fallIdx = 0;
  logic hist [4096];
  logic [CB-1:0] expHold [CH], expHold2 [CH];

  always #2.5 clk = ~clk;

  dac_frame_rx u_dac_frame_rx (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .fsIn(fs), .dinIn(din), .modeUc(modeUc),
    .loadN(loadN), .doutOut(dout), .frameDone(done), .latchOut(lat)
  );

  dac_frame_rx #(.RES_BITS(8)) u_dac_frame_rx_res8 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .fsIn(fs), .dinIn(din), .modeUc(modeUc),
    .loadN(loadN), .doutOut(dout2), .frameDone(done2), .latchOut(lat2)
  );

  always @(posedge clk) if (done) doneCnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R11 packing: channel c at bits [12c+11:12c]
  function automatic logic [VW-1:0] packExp(input bit res8);
    logic [VW-1:0] v;
    for (int c = 0; c < CH; c++) v[c*CB +: CB] = res8 ? expHold2[c] : expHold[c];
    return v;
  endfunction

  logic [VW-1:0] expLat, expLat2;

  task automatic syncLatModel();
    if (!loadN) begin
      expLat  = packExp(1'b0);
      expLat2 = packExp(1'b1);
    end
  endtask

  task automatic modelCommit(input logic [15:0] w);
    if (w[15] == 1'b0) begin
      expHold[w[14:12]]  = w[11:0];
      expHold2[w[14:12]] = w[11:0] & 12'hFF0;
    end
    syncLatModel();
  endtask

  // R8: each fall compares the pass-through to the bit 16 falls earlier
  task automatic sclkPulse();
    logic expD;
    sclk = 1'b1; tick(5);
    sclk = 1'b0; hist[fallIdx] = din; tick(5);
    expD = (fallIdx >= 16) ? hist[fallIdx-16] : 1'b0;
    chk(dout == expD, "R8 dout delay", VW'(dout), VW'(expD));
    fallIdx++;
  endtask

  task automatic ucFrame(input logic [15:0] w, input int nBits, input bit holdCheck);
    int d0;
    fs = 1'b0; tick(5);
    for (int i = 0; i < nBits; i++) begin
      din = w[15-i];
      sclkPulse();
    end
    if (holdCheck) begin
      d0 = doneCnt; tick(10);
      chk(doneCnt == d0 && lat == expLat, "R2 no commit while fs low", lat, expLat);
    end
    fs = 1'b1; tick(10);
  endtask

  task automatic dspFrame(input logic [15:0] w, input bit lead);
    if (lead) sclkPulse();
    fs = 1'b0; tick(3);
    for (int i = 0; i < 16; i++) begin
      din = w[15-i];
      sclkPulse();
      if (i == 0) fs = 1'b1;
    end
    tick(10);
  endtask

  function automatic logic [11:0] sweepCode(input int ch, input int k);
    if (k == 0) return 12'h000;
    if (k == 1) return 12'hFFF;
    return 12'((ch * 12'h2D3 + k * 12'h5A7 + 12'h0F1) & 12'hFFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    logic [15:0] w;
    for (int c = 0; c < CH; c++) begin expHold[c] = '0; expHold2[c] = '0; end
    expLat = '0; expLat2 = '0;
    tick(5); rstN = 1'b1; tick(5);
    chk(lat == '0 && dout == 1'b0 && doneCnt == 0 && done == 1'b0, "R1 reset state", lat, '0);

    // R2 / R9 / R11: microcontroller sweep over all channels and several codes
    loadN = 1'b0; tick(6); syncLatModel();
    for (int ch = 0; ch < CH; ch++) begin
      for (int k = 0; k < 4; k++) begin
        w = {1'b0, 3'(ch), sweepCode(ch, k)};
        d0 = doneCnt;
        ucFrame(w, 16, 1'b0);
        modelCommit(w);
        chk(doneCnt == d0 + 1, "R2 one commit pulse", VW'(doneCnt - d0), VW'(1));
        chk(lat == expLat, "R2 R11 channel write", lat, expLat);
        chk(lat2 == expLat2, "R9 reduced resolution", lat2, expLat2);
      end
    end

    // R2: nothing before the rise
    w = 16'h3ABC; d0 = doneCnt;
    ucFrame(w, 16, 1'b1); modelCommit(w);
    chk(doneCnt == d0 + 1 && lat == expLat, "R2 commit on rise", lat, expLat);

    // R3: short frames are discarded
    for (int n = 1; n < 16; n += 7) begin
      d0 = doneCnt;
      ucFrame(16'h1777, n, 1'b0);
      chk(doneCnt == d0 && lat == expLat, "R3 cancel", lat, expLat);
    end

    // R10: stray edge after the rise, then a normal frame
    w = 16'h4123; ucFrame(w, 16, 1'b0); modelCommit(w);
    sclkPulse(); tick(5);
    chk(lat == expLat, "R10 stray edge ignored", lat, expLat);
    w = 16'h5456; d0 = doneCnt; ucFrame(w, 16, 1'b0); modelCommit(w);
    chk(doneCnt == d0 + 1 && lat == expLat, "R10 next frame", lat, expLat);

    // R7: field 8 and above writes nothing
    for (int f = 8; f < 16; f += 7) begin
      d0 = doneCnt;
      ucFrame({4'(f), 12'hEEE}, 16, 1'b0);
      chk(doneCnt == d0 + 1 && lat == expLat, "R7 field out of range", lat, expLat);
    end

    // R6: staged writes while load released, then released together
    loadN = 1'b1; tick(6);
    w = 16'h2A5A; ucFrame(w, 16, 1'b0); modelCommit(w);
    w = 16'h5C3C; ucFrame(w, 16, 1'b0); modelCommit(w);
    chk(lat == expLat, "R6 latches hold", lat, expLat);
    loadN = 1'b0; tick(6); syncLatModel();
    chk(lat == expLat && lat2 == expLat2, "R6 simultaneous update", lat, expLat);

    // R4: DSP framing over all channels
    modeUc = 1'b0; tick(4);
    for (int ch = 0; ch < CH; ch++) begin
      w = {1'b0, 3'(ch), sweepCode(ch, 2 + (ch & 1)) ^ 12'h909};
      d0 = doneCnt;
      dspFrame(w, 1'b1); modelCommit(w);
      chk(doneCnt == d0 + 1 && lat == expLat, "R4 DSP commit", lat, expLat);
    end

    // R5: no lead edge after the previous frame -> ignored
    d0 = doneCnt;
    dspFrame(16'h0321, 1'b0);
    chk(doneCnt == d0 && lat == expLat, "R5 missing lead edge", lat, expLat);
    w = 16'h0654; d0 = doneCnt;
    dspFrame(w, 1'b1); modelCommit(w);
    chk(doneCnt == d0 + 1 && lat == expLat, "R5 lead edge accepts", lat, expLat);

    tick(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule